// File: doc/BRIEF.md
# Buffered Scan-Code Serializer with Latch Handshake

This block queues incoming scan-code bytes and hands them, one at a time, to an external serial-in parallel-out shift register that a slow host reads. Flow control uses an external set/reset latch. After the host has read the parallel byte, it sets the latch. The block sees the latch output high, shifts the oldest queued byte out on a serial data line with its own shift clock, and then pulses the latch reset input. The latch output falls, which tells the host that a fresh byte is waiting.

The latch output is brought through a two-flop synchronizer before use. A state machine drives the serializer. S_IDLE waits for a byte and a ready host. S_SETUP presents a bit with the clock high. S_CLK_LO holds the clock low. S_CLK_HI raises the clock, which is the capture edge. S_RST_HI drives the latch reset. S_WAIT_CLR waits for the latch to read low.

The transitions are:
- S_IDLE to S_SETUP when the queue is not empty and the synchronized latch level is high. The head byte is popped in this transition.
- S_SETUP to S_CLK_LO, S_CLK_LO to S_CLK_HI, and S_CLK_HI to S_SETUP, each after PHASE_CYC cycles. The step from S_CLK_HI back to S_SETUP happens while fewer than eight bits have been sent.
- S_CLK_HI to S_RST_HI after the eighth bit.
- S_RST_HI to S_WAIT_CLR after PHASE_CYC cycles.
- S_WAIT_CLR to S_IDLE once the synchronized latch level reads low.

Top module: `scan_latch_tx`

## Requirements
- R1: While reset is held and after it is released, the shift clock is high, the latch reset line is low, the serial data line is low and the overflow flag is low.
- R2: No shift clock activity begins while the latch output is low. Queued bytes are kept until the host sets the latch.
- R3: Bytes leave in the order they were written, each most-significant bit first, so the external register holds the written byte after its eighth rising clock edge.
- R4: For every bit, the data line changes only while the shift clock is high. The clock then stays low for PHASE_CYC cycles and rises, and the data line does not change from the falling edge through the rising edge.
- R5: Each byte gets exactly eight rising shift-clock edges. These are followed by one latch reset pulse, high for PHASE_CYC cycles, during which the shift clock stays high.
- R6: After a latch reset pulse, no new byte starts until the synchronized latch level has been seen low and then high again.
- R7: A write that arrives while DEPTH bytes are held is discarded, and it sets the overflow flag. The flag stays set until reset.
- R8: The queue counts as empty when its read and write positions are equal and it is not full. Both positions wrap back to the first slot after the last one, and a pop only happens when the queue is not empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Writes wr_data into the queue this cycle |
| wr_data | input | 8 | Scan-code byte to queue |
| latch_q | input | 1 | Latch output, high once the host has read the last byte |
| ser_data | output | 1 | Serial data to the shift register, MSB first |
| ser_clk | output | 1 | Shift clock; the register captures on the rising edge |
| latch_rst | output | 1 | Latch reset pulse marking a new byte as ready |
| overflow | output | 1 | Sticky flag set by a write dropped on a full queue |

## Verification
The assertions assume that the latch output only falls as a result of the block's own reset pulse, and only rises when the host sets it. They also assume the latch really does clear within a couple of cycles of that pulse. The bench models the latch in exactly this way. Its host sets the latch only after a random delay once the latch has gone low. In the random phase the bench writes only while fewer than DEPTH bytes are outstanding, so overflow appears only in the directed case that fills the queue while the host is held off.

// File: rtl/scan_latch_pkg.sv
package scan_latch_pkg;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_SETUP    = 3'd1,
        S_CLK_LO   = 3'd2,
        S_CLK_HI   = 3'd3,
        S_RST_HI   = 3'd4,
        S_WAIT_CLR = 3'd5
    } tx_state_e;

endpackage

// File: rtl/level_sync.sv
module level_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/scan_fifo.sv
module scan_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop, ovf_q;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign empty   = (wr_ptr == rd_ptr) && !full;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];
    assign overflow = ovf_q;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= step(wr_ptr);
            if (do_pop)  rd_ptr <= step(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
            if (push && full) ovf_q <= 1'b1;
        end
    end

    // R8: pops are only requested against a non-empty queue
    p_pop_nonempty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R7: a write on a full queue without a pop leaves it full and flags it
    p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && overflow));

    // R7: overflow never clears outside reset
    p_overflow_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
endmodule

// File: rtl/shift_tx.sv
module shift_tx
    import scan_latch_pkg::*;
#(
    parameter int W         = 8,
    parameter int PHASE_CYC = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         host_ready,
    input  logic         q_empty,
    input  logic [W-1:0] q_head,
    output logic         pop,
    output logic         ser_data,
    output logic         ser_clk,
    output logic         latch_rst
);
    localparam int PW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam int BW = (W > 1) ? $clog2(W) : 1;

    tx_state_e     state_q, state_d;
    logic [W-1:0]  shreg;
    logic [BW-1:0] bitcnt;
    logic [PW-1:0] phase_cnt;
    logic          phase_done, last_bit, launch;

    assign phase_done = (phase_cnt == PW'(PHASE_CYC - 1));
    assign last_bit   = (bitcnt == BW'(W - 1));
    assign launch     = (state_q == S_IDLE) && host_ready && !q_empty;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (launch)     state_d = S_SETUP;
            S_SETUP:    if (phase_done) state_d = S_CLK_LO;
            S_CLK_LO:   if (phase_done) state_d = S_CLK_HI;
            S_CLK_HI:   if (phase_done) state_d = last_bit ? S_RST_HI : S_SETUP;
            S_RST_HI:   if (phase_done) state_d = S_WAIT_CLR;
            S_WAIT_CLR: if (!host_ready) state_d = S_IDLE;
            default:                    state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bitcnt    <= '0;
            phase_cnt <= '0;
        end else begin
            if (state_d != state_q) phase_cnt <= '0;
            else if (!phase_done)   phase_cnt <= phase_cnt + PW'(1);

            if (launch) begin
                shreg  <= q_head;
                bitcnt <= '0;
            end else if (state_q == S_CLK_HI && phase_done && !last_bit) begin
                shreg  <= {shreg[W-2:0], 1'b0};
                bitcnt <= bitcnt + BW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        pop       = launch;
        ser_data  = shreg[W-1];
        ser_clk   = (state_q != S_CLK_LO);
        latch_rst = (state_q == S_RST_HI);
    end

    // R4: data holds still through the whole low phase and its rising edge
    p_data_stable_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_clk |=> $stable(ser_data));

    // R5: the latch pulse only starts after the final bit's high phase
    p_pulse_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_rst) |-> ($past(state_q) == S_CLK_HI && last_bit));

    // R5: shift clock stays high while the latch is being reset
    p_clk_high_in_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        latch_rst |-> ser_clk);

    // R6: no return to idle while the latch still reads as set
    p_wait_for_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT_CLR && host_ready) |=> (state_q == S_WAIT_CLR));

    // R2: the clock never falls while the host has not released the latch
    p_hold_when_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !host_ready) |=> ser_clk);
endmodule

// File: rtl/scan_latch_tx.sv
module scan_latch_tx #(
    parameter int DEPTH     = 16,
    parameter int PHASE_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_valid,
    input  logic [7:0] wr_data,
    input  logic       latch_q,
    output logic       ser_data,
    output logic       ser_clk,
    output logic       latch_rst,
    output logic       overflow
);
    localparam int W = 8;

    logic         host_ready, q_empty, q_full, pop;
    logic [W-1:0] q_head;

    level_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (latch_q),
        .dout (host_ready)
    );

    scan_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (wr_valid),
        .din     (wr_data),
        .pop     (pop),
        .dout    (q_head),
        .empty   (q_empty),
        .full    (q_full),
        .overflow(overflow)
    );

    shift_tx #(.W(W), .PHASE_CYC(PHASE_CYC)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_ready(host_ready),
        .q_empty   (q_empty),
        .q_head    (q_head),
        .pop       (pop),
        .ser_data  (ser_data),
        .ser_clk   (ser_clk),
        .latch_rst (latch_rst)
    );

    // R1: idle output levels right after reset
    p_reset_levels_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ser_clk && !latch_rst && !overflow));

    // R7: a full queue raises overflow on any write attempt
    p_full_write_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full && wr_valid) |=> overflow);
endmodule

// File: tb/test_scan_latch_tx.sv
module test_scan_latch_tx;
    localparam int DEPTH = 16;
    localparam int PHASE = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       latch_q = 1'b0;
    logic       ser_data, ser_clk, latch_rst, overflow;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [7:0] exp_q [0:511];
    int exp_wr = 0;
    int exp_rd = 0;
    logic [7:0] cap = '0;
    int pulses = 0;
    int lo_cycles = 0;
    bit host_en = 1'b0;
    int host_dly = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    scan_latch_tx #(.DEPTH(DEPTH), .PHASE_CYC(PHASE)) i_scan_latch_tx (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .latch_q(latch_q), .ser_data(ser_data), .ser_clk(ser_clk),
        .latch_rst(latch_rst), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int outstanding();
        return exp_wr - exp_rd;
    endfunction

    // external shift register model
    always @(posedge ser_clk) begin
        cap = {cap[6:0], ser_data};
        pulses++;
    end

    // R2/R6: the clock must not fall while the latch output is low
    always @(negedge ser_clk) begin
        if (rst_n) check(latch_q == 1'b1, "R2/R6 clock fell while latch low", 0, 1);
    end

    // R3/R5: at each latch reset pulse, compare byte and edge count
    always @(posedge latch_rst) begin
        check(pulses == 8, "R5 edges per byte", pulses, 8);
        check(cap == exp_q[exp_rd], "R3 byte order / MSB first", cap, exp_q[exp_rd]);
        exp_rd++;
        pulses = 0;
    end

    // R4: low phase width
    always @(negedge clk) begin
        if (rst_n && !ser_clk) lo_cycles++;
        else if (lo_cycles != 0) begin
            check(lo_cycles == PHASE, "R4 clock low width", lo_cycles, PHASE);
            lo_cycles = 0;
        end
    end

    // latch and host model
    initial begin
        forever begin
            @(negedge clk);
            if (latch_rst) begin
                latch_q  = 1'b0;
                host_dly = $urandom_range(0, 12);
            end else if (!latch_q && host_en) begin
                if (host_dly == 0) latch_q = 1'b1;
                else host_dly--;
            end
        end
    end

    // watchdog
    initial begin
        while (!done && cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            check(1'b0, "watchdog", cycles, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic write_byte(input logic [7:0] v, input bit expect_kept);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = v;
        @(negedge clk);
        wr_valid = 1'b0;
        if (expect_kept) begin
            exp_q[exp_wr] = v;
            exp_wr++;
        end
    endtask

    task automatic drain();
        int t = 0;
        while (exp_rd != exp_wr && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (10) @(negedge clk);
        check(exp_rd == exp_wr, "R3 all bytes delivered", exp_rd, exp_wr);
    endtask

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R1: levels during reset
        check(ser_clk == 1'b1 && latch_rst == 1'b0, "R1 reset clock/pulse", {ser_clk, latch_rst}, 2'b10);
        check(overflow == 1'b0 && ser_data == 1'b0, "R1 reset overflow/data", {overflow, ser_data}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(ser_clk == 1'b1 && latch_rst == 1'b0 && overflow == 1'b0, "R1 after release",
              {ser_clk, latch_rst, overflow}, 3'b100);

        // R7/R2: fill while host holds the latch low, then three extra writes
        for (int i = 0; i < DEPTH + 3; i++)
            write_byte(8'(8'hA0 + i * 7), i < DEPTH);
        repeat (40) @(negedge clk);
        check(pulses == 0, "R2 no shifting while latch low", pulses, 0);
        check(overflow == 1'b1, "R7 overflow on full write", overflow, 1);

        // release host; R8 wrap exercised by draining a full queue
        host_en = 1'b1;
        host_dly = 2;
        drain();
        check(overflow == 1'b1, "R7 overflow sticky", overflow, 1);

        // directed corner bytes: all zeros, all ones, single MSB, single LSB
        write_byte(8'h00, 1'b1);
        write_byte(8'hFF, 1'b1);
        write_byte(8'h80, 1'b1);
        write_byte(8'h01, 1'b1);
        drain();

        // random stream, never more than DEPTH outstanding (R3, R8 wrap)
        for (int n = 0; n < 60; n++) begin
            while (outstanding() >= DEPTH) @(negedge clk);
            write_byte(8'($urandom), 1'b1);
            repeat ($urandom_range(0, 40)) @(negedge clk);
        end
        drain();
        check(latch_rst == 1'b0 && ser_clk == 1'b1, "R5 idle after stream",
              {latch_rst, ser_clk}, 2'b01);

        // R1/R7: reset clears the sticky flag
        rst_n = 1'b0;
        @(negedge clk);
        check(overflow == 1'b0, "R1 R7 overflow cleared by reset", overflow, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule